// File: doc/BRIEF.md
# Watchdog and Interval Timer with Clock Fail-Safe

This block is a supervision timer for a processor subsystem. A free-running counter advances on ticks from one of four selectable clock sources: 0 = system clock, 1 = auxiliary clock, 2 = slow always-on oscillator, 3 = external clock. Each source reaches the block as a single-cycle enable pulse that is synchronous to the bus clock. Software configures the block through a keyed control register and a status register.

In watchdog mode, expiry of the selected counter tap raises a reset request. In interval mode, expiry sets a periodic interrupt flag. The block leaves reset in watchdog mode and counting, so software has to stop it or service it explicitly.

A sticky fault latch on the system and auxiliary sources drives a fail-safe. In watchdog mode, once the selected main source has reported a fault, the counter is re-clocked from the slow oscillator. The timeout therefore stretches, but it still arrives. This switch stays in place after the fault input clears.

Top module: `guard_timer`

## Requirements
- R1: After reset the control register reads 0x9604: watchdog mode, system source, tap select 4 (2^15 ticks), not held. The status register reads 0x0000. Left alone, the block raises `rst_req` after 2^15 system ticks.
- R2: A control write (`addr`=0) takes effect only when `wr_data[15:8]` is 0x5A. The fields are: `[2:0]` tap select, `[3]` counter clear, `[4]` mode (1 = interval), `[6:5]` source, `[7]` hold. A read returns 0x96 in `[15:8]` and 0 in bit 3.
- R3: A control write with any other key raises `rst_req` on the next cycle, sets status bit 2 (key violation, cleared by writing 1 to it) and returns the control register to its reset value.
- R4: In watchdog mode, the tick that completes 2^n effective ticks since the last clear raises `rst_req`. `rst_req` then stays high for exactly 16 bus cycles, the control register returns to its reset value and the count restarts from zero.
- R5: Tap select values 0 to 7 give expiry periods of 2^31, 2^27, 2^23, 2^19, 2^15, 2^13, 2^9 and 2^6 effective ticks.
- R6: In interval mode, each expiry sets status bit 0 and the counter keeps running, so the flag recurs every 2^n ticks. `irq` equals flag AND status bit 1 (enable), one cycle after either changes. Writing 1 to status bit 0 clears the flag.
- R7: Writing the clear bit makes the next effective tick reset the count to zero instead of advancing it.
- R8: While the hold bit is set, the counter does not advance and never expires.
- R9: In watchdog mode, with source 0 or 1 selected and that source's fault latch set, the counter advances on slow-oscillator ticks and status bit 5 reads 1.
- R10: A fault pulse on `src_fault[i]` sets status bit 3+i. The bit stays set after the input falls and clears only when software writes 1 to it.
- R11: In interval mode, the fail-safe never applies: the selected source's ticks are used and status bit 5 reads 0, even with a fault latch set.
- R12: While `rst_req` is high, all register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 status |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data for `addr` from the previous cycle |
| src_tick | input | 4 | Per-source tick enables, one bus cycle wide |
| src_fault | input | 2 | Fault indications for the system (0) and auxiliary (1) sources |
| rst_req | output | 1 | Reset request to the system reset controller |
| irq | output | 1 | Interval interrupt request |

## Verification
The hardest state to reach is a fail-safe timeout: the fault must be latched while the block is in watchdog mode with a main source selected, and the fault input must already be gone when the expiry arrives. The stimulus therefore pulses the system fault for a single cycle just after a kick, and then lets the slow source, which ticks every seventh cycle, run the short tap to expiry. It then enters interval mode while that latch is still set, to show that the fail-safe does not apply there. A behavioural reference model runs beside the design, so every cycle of these long waits is compared, not only their end points.

// File: rtl/gtmr_pkg.sv
`timescale 1ns/1ps
package gtmr_pkg;
  localparam int GT_SRC_W = 2;

  typedef struct packed {
    logic                hold;
    logic [GT_SRC_W-1:0] src;
    logic                ival;
    logic [2:0]          tap;
  } gt_ctrl_t;

  localparam gt_ctrl_t GT_CTRL_DEF = '{hold: 1'b0, src: '0, ival: 1'b0, tap: 3'd4};

  // Exponent of the expiry period for each tap select value
  function automatic int tap_exp(input logic [2:0] sel);
    case (sel)
      3'd0:    return 31;
      3'd1:    return 27;
      3'd2:    return 23;
      3'd3:    return 19;
      3'd4:    return 15;
      3'd5:    return 13;
      3'd6:    return 9;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/gt_clksel.sv
`timescale 1ns/1ps
module gt_clksel #(
  parameter int SRC_W    = 2,
  parameter int NFLT     = 2,
  parameter int SLOW_SRC = 2,
  localparam int NSRC    = 1 << SRC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ival,
  input  logic [SRC_W-1:0] src,
  input  logic [NFLT-1:0]  fault_in,
  input  logic [NFLT-1:0]  flt_clr,
  input  logic [NSRC-1:0]  src_tick,
  output logic             tick,
  output logic [NFLT-1:0]  fault_lat,
  output logic             fs_active
);
  logic [SRC_W-1:0] eff;

  // Sticky per-source fault latches
  for (genvar i = 0; i < NFLT; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) fault_lat[i] <= 1'b0;
      else     fault_lat[i] <= (fault_lat[i] & ~flt_clr[i]) | fault_in[i];
    end
  end

  always_comb begin
    eff = src;
    for (int i = 0; i < NFLT; i++) begin
      if (!ival && src == SRC_W'(i) && fault_lat[i]) eff = SRC_W'(SLOW_SRC);
    end
  end

  assign tick      = src_tick[eff];
  assign fs_active = (eff != src);

  AST_FAILSAFE_SWITCH: assert property (@(posedge clk) disable iff (rst) (!ival && src == '0 && fault_in[0]) ##1 (!ival && src == '0) |-> tick == src_tick[SLOW_SRC]); // R9
endmodule

// File: rtl/gt_counter.sv
`timescale 1ns/1ps
module gt_counter #(
  parameter int CNT_W = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       clr_set,
  input  logic       hold,
  input  logic [2:0] tap,
  input  logic       frozen,
  input  logic       zap,
  output logic       expire
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] mask;
  logic             pend;

  always_comb begin
    mask = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < gtmr_pkg::tap_exp(tap)) mask[b] = 1'b1;
    end
  end

  assign expire = tick & ~frozen & ~pend & ~hold & ((count & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || frozen || zap) begin
      count <= '0;
      pend  <= 1'b0;
    end else begin
      if (tick) begin
        if (pend)       count <= '0;
        else if (!hold) count <= count + 1'b1;
      end
      pend <= clr_set | (pend & ~tick);
    end
  end

  AST_KICK_ZERO: assert property (@(posedge clk) disable iff (rst) (pend && tick) |=> count == '0); // R7
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst) (hold && !pend && !frozen && !zap) |=> $stable(count)); // R8
endmodule

// File: rtl/gt_regs.sv
`timescale 1ns/1ps
module gt_regs #(
  parameter int          NFLT    = 2,
  parameter int          RST_CYC = 16,
  parameter logic [7:0]  WR_KEY  = 8'h5A,
  parameter logic [7:0]  RD_KEY  = 8'h96,
  localparam int         HC_W    = $clog2(RST_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                addr,
  input  logic [15:0]         wr_data,
  input  logic                expire,
  input  logic [NFLT-1:0]     fault_lat,
  input  logic                fs_active,
  output gtmr_pkg::gt_ctrl_t  ctrl,
  output logic                clr_set,
  output logic [NFLT-1:0]     flt_clr,
  output logic                zap,
  output logic                rst_req,
  output logic                irq,
  output logic [15:0]         rd_data
);
  import gtmr_pkg::*;

  logic            flag, ie, keyv;
  logic [HC_W-1:0] hcnt;
  logic            wr_ok, cwr, swr, bad_key, ctl_ok, flag_n, ie_n;
  logic [15:0]     ctl_rd, stat_rd;

  assign wr_ok   = wr_en & ~rst_req;
  assign cwr     = wr_ok & ~addr;
  assign swr     = wr_ok & addr;
  assign bad_key = cwr & (wr_data[15:8] != WR_KEY);
  assign ctl_ok  = cwr & (wr_data[15:8] == WR_KEY);
  assign clr_set = ctl_ok & wr_data[3];
  assign flt_clr = swr ? wr_data[3 +: NFLT] : '0;
  assign zap     = bad_key | (expire & ~ctrl.ival);
  assign flag_n  = (expire & ctrl.ival) | (flag & ~(swr & wr_data[0]));
  assign ie_n    = swr ? wr_data[1] : ie;

  assign ctl_rd  = {RD_KEY, ctrl.hold, ctrl.src, ctrl.ival, 1'b0, ctrl.tap};
  assign stat_rd = {{(12 - NFLT){1'b0}}, fs_active, fault_lat, keyv, ie, flag};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= GT_CTRL_DEF;
      flag    <= 1'b0;
      ie      <= 1'b0;
      keyv    <= 1'b0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
      hcnt    <= '0;
      rd_data <= '0;
    end else begin
      flag    <= flag_n;
      ie      <= ie_n;
      irq     <= flag_n & ie_n;
      rd_data <= addr ? stat_rd : ctl_rd;
      if (zap) begin
        rst_req <= 1'b1;
        hcnt    <= HC_W'(RST_CYC);
        ctrl    <= GT_CTRL_DEF;
        if (bad_key) keyv <= 1'b1;
      end else if (rst_req) begin
        if (hcnt == HC_W'(1)) begin
          rst_req <= 1'b0;
          hcnt    <= '0;
        end else begin
          hcnt <= hcnt - 1'b1;
        end
      end else begin
        if (ctl_ok) ctrl <= '{hold: wr_data[7], src: wr_data[6:5], ival: wr_data[4], tap: wr_data[2:0]};
        if (swr && wr_data[2]) keyv <= 1'b0;
      end
    end
  end

  AST_BAD_KEY_RESET: assert property (@(posedge clk) disable iff (rst) (wr_en && !rst_req && !addr && wr_data[15:8] != WR_KEY) |=> (rst_req && keyv)); // R3
  AST_HOLD_WIDTH: assert property (@(posedge clk) disable iff (rst) (rst_req && hcnt > HC_W'(1)) |=> rst_req); // R4
  AST_WDOG_EXPIRY: assert property (@(posedge clk) disable iff (rst) (expire && !ctrl.ival) |=> rst_req); // R4
  AST_IVAL_FLAG: assert property (@(posedge clk) disable iff (rst) (expire && ctrl.ival) |=> flag); // R6
  AST_WRITES_IGNORED: assert property (@(posedge clk) disable iff (rst) rst_req |=> $stable(ctrl)); // R12
endmodule

// File: rtl/guard_timer.sv
`timescale 1ns/1ps
module guard_timer #(
  parameter int         CNT_W    = 32,
  parameter int         NFLT     = 2,
  parameter int         SLOW_SRC = 2,
  parameter int         RST_CYC  = 16,
  parameter logic [7:0] WR_KEY   = 8'h5A,
  parameter logic [7:0] RD_KEY   = 8'h96,
  localparam int        SRC_W    = gtmr_pkg::GT_SRC_W,
  localparam int        NSRC     = 1 << SRC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [15:0]      wr_data,
  output logic [15:0]      rd_data,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [NFLT-1:0]  src_fault,
  output logic             rst_req,
  output logic             irq
);
  gtmr_pkg::gt_ctrl_t ctrl;
  logic               tick, expire, clr_set, zap, fs_active;
  logic [NFLT-1:0]    fault_lat, flt_clr;

  gt_regs #(.NFLT(NFLT), .RST_CYC(RST_CYC), .WR_KEY(WR_KEY), .RD_KEY(RD_KEY)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .expire(expire), .fault_lat(fault_lat), .fs_active(fs_active),
    .ctrl(ctrl), .clr_set(clr_set), .flt_clr(flt_clr), .zap(zap),
    .rst_req(rst_req), .irq(irq), .rd_data(rd_data)
  );

  gt_clksel #(.SRC_W(SRC_W), .NFLT(NFLT), .SLOW_SRC(SLOW_SRC)) u_clksel (
    .clk(clk), .rst(rst), .ival(ctrl.ival), .src(ctrl.src), .fault_in(src_fault),
    .flt_clr(flt_clr), .src_tick(src_tick), .tick(tick), .fault_lat(fault_lat),
    .fs_active(fs_active)
  );

  gt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .tick(tick), .clr_set(clr_set), .hold(ctrl.hold),
    .tap(ctrl.tap), .frozen(rst_req), .zap(zap), .expire(expire)
  );
endmodule

// File: tb/guard_timer_test.sv
`timescale 1ns/1ps
module guard_timer_test;
  logic        clk = 0, rst = 1, wr_en = 0, addr = 0;
  logic [15:0] wr_data = 0;
  logic [3:0]  src_tick = 0;
  logic [1:0]  src_fault = 0;
  logic [15:0] rd_data;
  logic        rst_req, irq;
  int          checks = 0, fails = 0, cyc = 0;

  guard_timer uut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .src_tick(src_tick), .src_fault(src_fault), .rst_req(rst_req), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_tap, m_src, m_hold, m_mode, m_ie, m_flag, m_keyv, m_rst, m_left, m_pend, m_irq, m_rd;
  int m_lat[2];
  longint m_cnt;

  function automatic int texp(int s);
    int t[8] = '{31, 27, 23, 19, 15, 13, 9, 6};
    return t[s];
  endfunction

  always @(posedge clk) begin
    int eff, tk, sw, cw, bad, cok, n, expn, start, nf, ni;
    longint per;
    cyc++;
    if (rst) begin
      m_tap = 4; m_src = 0; m_hold = 0; m_mode = 0; m_ie = 0; m_flag = 0; m_keyv = 0;
      m_rst = 0; m_left = 0; m_pend = 0; m_irq = 0; m_rd = 0; m_cnt = 0;
      m_lat[0] = 0; m_lat[1] = 0;
    end else begin
      eff = m_src;
      if (m_mode == 0 && m_src < 2 && m_lat[m_src] != 0) eff = 2;
      tk  = src_tick[eff];
      sw  = (wr_en && m_rst == 0 && addr) ? 1 : 0;
      cw  = (wr_en && m_rst == 0 && !addr) ? 1 : 0;
      bad = (cw != 0 && wr_data[15:8] != 8'h5A) ? 1 : 0;
      cok = (cw != 0 && bad == 0) ? 1 : 0;
      n   = texp(m_tap);
      per = longint'(1) << n;
      expn = (tk != 0 && m_rst == 0 && m_pend == 0 && m_hold == 0 && (m_cnt % per) == per - 1) ? 1 : 0;
      start = (bad != 0 || (expn != 0 && m_mode == 0)) ? 1 : 0;
      if (addr) m_rd = m_flag | (m_ie << 1) | (m_keyv << 2) | (m_lat[0] << 3) | (m_lat[1] << 4) | ((eff != m_src) << 5);
      else      m_rd = 'h9600 | (m_hold << 7) | (m_src << 5) | (m_mode << 4) | m_tap;
      nf = (expn != 0 && m_mode != 0) ? 1 : ((sw != 0 && wr_data[0]) ? 0 : m_flag);
      ni = (sw != 0) ? int'(wr_data[1]) : m_ie;
      for (int i = 0; i < 2; i++)
        m_lat[i] = (((sw != 0 && wr_data[3 + i]) ? 0 : m_lat[i]) != 0 || src_fault[i]) ? 1 : 0;
      if (start != 0 || m_rst != 0) begin
        m_cnt = 0; m_pend = 0;
      end else begin
        if (tk != 0) begin
          if (m_pend != 0) m_cnt = 0;
          else if (m_hold == 0) m_cnt++;
        end
        m_pend = (cok != 0 && wr_data[3]) ? 1 : (tk != 0 ? 0 : m_pend);
      end
      if (start != 0) begin
        m_rst = 1; m_left = 16; m_tap = 4; m_src = 0; m_hold = 0; m_mode = 0;
        if (bad != 0) m_keyv = 1;
      end else if (m_rst != 0) begin
        m_left--;
        if (m_left == 0) m_rst = 0;
      end else begin
        if (cok != 0) begin
          m_tap = wr_data[2:0]; m_mode = wr_data[4]; m_src = wr_data[6:5]; m_hold = wr_data[7];
        end
        if (sw != 0 && wr_data[2]) m_keyv = 0;
      end
      m_flag = nf; m_ie = ni; m_irq = (nf != 0 && ni != 0) ? 1 : 0;
    end
  end

  // per-cycle comparison, then tick pattern for the next cycle
  always @(negedge clk) begin
    if (!rst) begin
      chk(rst_req == m_rst[0], "R4 model rst_req", rst_req, m_rst);
      chk(irq == m_irq[0], "R6 model irq", irq, m_irq);
      chk(rd_data == m_rd[15:0], "R2 model rd_data", rd_data, m_rd);
    end
    src_tick <= {cyc % 3 == 0, cyc % 7 == 0, cyc % 2 == 0, 1'b1};
  end

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; addr = 0; wr_data = 0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rd_data; addr = 0;
  endtask

  task automatic wait_for(input bit want_rst, input int lim, output int n);
    n = 0;
    while (((want_rst ? rst_req : irq) == 1'b0) && n < lim) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL run timeout act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n, t1, t2;
    repeat (5) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(1'b0, v); chk(v == 16'h9604, "R1 ctrl reset", v, 16'h9604);
    rd(1'b1, v); chk(v == 16'h0000, "R1 status reset", v, 0);
    // R8 hold
    wr(1'b0, 16'h5A87);
    rd(1'b0, v); chk(v == 16'h9687, "R2 R8 ctrl readback hold", v, 16'h9687);
    repeat (300) @(negedge clk);
    chk(rst_req == 1'b0, "R8 no expiry while held", rst_req, 0);
    // R2 R6 interval mode, clear bit reads zero
    wr(1'b0, 16'h5A1F);
    rd(1'b0, v); chk(v == 16'h9617, "R2 clear bit reads zero", v, 16'h9617);
    wr(1'b1, 16'h0002);
    wait_for(1'b0, 200, n); chk(irq == 1'b1, "R6 irq in interval mode", irq, 1);
    wr(1'b1, 16'h0003);
    chk(irq == 1'b0, "R6 flag cleared by write", irq, 0);
    // R5 period of tap 6
    wr(1'b0, 16'h5A1E);
    wait_for(1'b0, 1000, n); t1 = cyc;
    wr(1'b1, 16'h0003);
    wait_for(1'b0, 1000, n); t2 = cyc;
    chk(t2 - t1 == 512, "R5 tap 2^9 period", t2 - t1, 512);
    wr(1'b1, 16'h0001);
    // R7 kicks keep the watchdog quiet
    wr(1'b0, 16'h5A0F);
    for (int k = 0; k < 10; k++) begin
      repeat (38) @(negedge clk);
      wr(1'b0, 16'h5A0F);
    end
    chk(rst_req == 1'b0, "R7 kicked watchdog silent", rst_req, 0);
    wait_for(1'b1, 200, n);
    chk(rst_req == 1'b1 && n < 70, "R4 expiry without kick", n, 64);
    n = 0;
    while (rst_req) begin @(negedge clk); n++; end
    chk(n == 16, "R4 reset request width", n, 16);
    rd(1'b0, v); chk(v == 16'h9604, "R4 ctrl back to default", v, 16'h9604);
    // R3 wrong key, R12 writes ignored during request
    wr(1'b0, 16'h1200);
    chk(rst_req == 1'b1, "R3 bad key raises reset", rst_req, 1);
    wr(1'b0, 16'h5A87);
    repeat (20) @(negedge clk);
    rd(1'b0, v); chk(v == 16'h9604, "R12 R3 write ignored during reset", v, 16'h9604);
    rd(1'b1, v); chk(v[2] == 1'b1, "R3 key violation flag", v[2], 1);
    wr(1'b1, 16'h0004);
    rd(1'b1, v); chk(v[2] == 1'b0, "R3 key violation cleared", v[2], 0);
    // R9 R10 fail-safe stretches the timeout
    wr(1'b0, 16'h5A0F);
    @(negedge clk); src_fault = 2'b01;
    @(negedge clk); src_fault = 2'b00;
    rd(1'b1, v); chk((v & 16'h0038) == 16'h0028, "R9 R10 fault latched, fail-safe on", v & 16'h38, 16'h28);
    wait_for(1'b1, 600, n);
    chk(rst_req == 1'b1 && n > 400 && n < 480, "R9 stretched timeout", n, 448);
    while (rst_req) @(negedge clk);
    // R11 interval mode ignores the latched fault
    wr(1'b0, 16'h5A1F);
    rd(1'b1, v); chk((v & 16'h0028) == 16'h0008, "R11 no fail-safe in interval", v & 16'h28, 16'h08);
    wr(1'b1, 16'h0002);
    wait_for(1'b0, 200, n);
    chk(irq == 1'b1 && n < 70, "R11 interval uses system ticks", n, 64);
    wr(1'b1, 16'h000B);
    rd(1'b1, v); chk(v[3] == 1'b0, "R10 fault latch cleared by write", v[3], 0);
    // R1 R5 default timeout from reset
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk); rst = 0;
    wait_for(1'b1, 40000, n);
    chk(rst_req == 1'b1 && n >= 32766 && n <= 32770, "R1 R5 default 2^15 timeout", n, 32768);
    repeat (20) @(negedge clk);
    summary();
    $finish;
  end
endmodule